// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block takes one raw PWM level and drives a complementary pair of gate signals from it: the even output is active while the raw level is high, and the odd output is active while it is low. Every change of the raw level, and every enable of the channel, opens a dead-time window. During that window neither output is active, so that the two switches of a half bridge are never on together.

The length of the window comes from a 12-bit programmed value multiplied by the divide ratio of the PWM clock prescaler. The ratio is 1, 2, 4 or 8, chosen by a 2-bit code. At a ratio of one the window equals the programmed value. At the other ratios it is one cycle shorter than the product. The programmed value and the prescaler code are captured when a window starts.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, both outputs are inactive (0) and no dead-time window is running.
- R2: The even and odd outputs are never high in the same cycle.
- R3: With `en` low, both outputs are 0 from the next clock edge. A rising `en` starts a dead-time window for the current raw level, in the same way as a raw edge.
- R4: Outputs are active high. `out_even` is the output for a raw level of 1 and `out_odd` is the output for a raw level of 0. On a raw edge the output that was active goes to 0 at the first clock edge that samples the new raw level.
- R5: For a programmed value DT and prescaler code `ps_sel` (00=÷1, 01=÷2, 10=÷4, 11=÷8, ratio P = 2^ps_sel), the window lasts D clock cycles. D = DT when ps_sel is 00, and D = P×DT−1 otherwise. The output that turns on goes high D clock edges after the edge that started the window.
- R6: With DT = 0 the outputs switch complementarily at the edge that samples the raw edge, with no gap, at every prescaler code.
- R7: A raw edge that arrives inside a running window restarts the window from the new raw level. Both outputs stay 0 until the restarted window expires.
- R8: DT and `ps_sel` are captured when a window starts. Changing them inside a window leaves that window's length unchanged and sets the length of the next one.
- R9: The full 12-bit range is supported: DT = 4095 gives 4095 cycles at ÷1 and 32759 cycles at ÷8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable |
| pwm_raw | input | 1 | Raw PWM level from the comparator |
| ps_sel | input | 2 | Prescaler ratio code |
| dt_val | input | 12 | Programmed dead-time value |
| out_even | output | 1 | Even (high-side) drive, active high |
| out_odd | output | 1 | Odd (low-side) drive, active high |

## Verification
A raw PWM edge can land in the same cycle as a running dead-time countdown. In that case a restart and an expiry compete for the same output register. The bench provokes this by toggling the raw level twice, a few cycles apart, inside one window. It then checks that the opposite output never pulses and that the gap counted from the second edge is the full window. A second collision comes from changing the dead-time value and the prescaler code just after a window has started: the measured length of that window must match the old settings, and the next window must match the new ones.

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen #(
  parameter int DT_W = 12,
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            pwm_raw,
  input  logic [PS_W-1:0] ps_sel,
  input  logic [DT_W-1:0] dt_val,
  output logic            out_even,
  output logic            out_odd
);

  localparam int CNT_W = DT_W + (1 << PS_W) - 1;

  logic             raw_q, en_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dt_ext, scaled, dead_len;
  logic             start;

  assign dt_ext   = CNT_W'(dt_val);
  assign scaled   = dt_ext << ps_sel;
  assign dead_len = (ps_sel == '0 || dt_val == '0) ? dt_ext : scaled - CNT_W'(1);
  assign start    = en && (!en_q || (pwm_raw != raw_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q    <= 1'b0;
      en_q     <= 1'b0;
      cnt      <= '0;
      out_even <= 1'b0;
      out_odd  <= 1'b0;
    end else begin
      raw_q <= pwm_raw;
      en_q  <= en;
      if (!en) begin
        cnt      <= '0;
        out_even <= 1'b0;
        out_odd  <= 1'b0;
      end else if (start) begin
        if (dead_len == '0) begin
          cnt      <= '0;
          out_even <= pwm_raw;
          out_odd  <= !pwm_raw;
        end else begin
          cnt      <= dead_len;
          out_even <= 1'b0;
          out_odd  <= 1'b0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          out_even <= raw_q;
          out_odd  <= !raw_q;
        end
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_even && !out_odd && cnt == '0));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_even && out_odd));

  p_disable_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_even && !out_odd));

  p_even_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_even |-> raw_q);

  p_odd_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_odd |-> !raw_q);

  p_gap_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dt_val != '0) |=> (!out_even && !out_odd && cnt != '0));

  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CNT_W'(1) && en && !start) |=> (!out_even && !out_odd));

  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dt_val == '0) |=> (out_even == $past(pwm_raw) && out_odd == !$past(pwm_raw)));

endmodule

// File: tb/tb_pwm_deadtime_gen.sv
module tb_pwm_deadtime_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam int WATCHDOG = 150000;

  // {raw, ps_sel[1:0], dt[11:0], expected gap[15:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b1, 2'd1, 12'd5,    16'd9},
    {1'b0, 2'd0, 12'd5,    16'd5},
    {1'b1, 2'd2, 12'd3,    16'd11},
    {1'b0, 2'd3, 12'd2,    16'd15},
    {1'b1, 2'd0, 12'd1,    16'd1},
    {1'b0, 2'd1, 12'd1,    16'd1},
    {1'b1, 2'd3, 12'd1,    16'd7},
    {1'b0, 2'd2, 12'd10,   16'd39},
    {1'b1, 2'd0, 12'd0,    16'd0},
    {1'b0, 2'd3, 12'd0,    16'd0},
    {1'b1, 2'd0, 12'd4095, 16'd4095},
    {1'b0, 2'd3, 12'd4095, 16'd32759}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pwm_raw = 1'b0;
  logic [1:0]  ps_sel = 2'd0;
  logic [11:0] dt_val = 12'd0;
  logic out_even, out_odd;
  int checks = 0, fails = 0, cycles = 0;

  pwm_deadtime_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_raw(pwm_raw),
    .ps_sel(ps_sel), .dt_val(dt_val), .out_even(out_even), .out_odd(out_odd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts low-low samples after the last drive until the target output rises.
  task automatic count_gap(input logic raw, output int gap, output int overlap, output int wrong);
    gap = 0; overlap = 0; wrong = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (out_even && out_odd) overlap++;
      if ((raw ? out_odd : out_even)) wrong++;
      if ((raw ? out_even : out_odd)) break;
      gap++;
    end
  endtask

  task automatic edge_and_measure(input logic raw, input logic [1:0] ps, input logic [11:0] dt,
                                  input int exp, input string req);
    int gap, ov, wr;
    @(negedge clk);
    pwm_raw = raw; ps_sel = ps; dt_val = dt;
    count_gap(raw, gap, ov, wr);
    check(req, gap, exp);
    check("R2", ov, 0);
    check("R4", wr, 0);
  endtask

  initial begin
    int gap, ov, wr;
    repeat (2) @(negedge clk);
    check("R1 even", int'(out_even), 0);
    check("R1 odd", int'(out_odd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(out_even | out_odd), 0);

    en = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 enable odd", int'(out_odd), 1);

    for (int v = 0; v < NVEC; v++)
      edge_and_measure(VEC[v][30], VEC[v][29:28], VEC[v][27:16], int'(VEC[v][15:0]),
                       (v >= 10) ? "R9" : (VEC[v][27:16] == 0) ? "R6" : "R5");

    // R7: restart inside a window (raw now 0, odd high)
    @(negedge clk);
    pwm_raw = 1'b1; ps_sel = 2'd0; dt_val = 12'd10;
    ov = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (out_even || out_odd) ov++;
    end
    pwm_raw = 1'b0;
    count_gap(1'b0, gap, ov, wr);
    check("R7 restarted gap", gap, 10);
    check("R7 no pulse", wr, 0);

    // R8: settings captured at window start
    @(negedge clk);
    pwm_raw = 1'b1; ps_sel = 2'd0; dt_val = 12'd6;
    @(negedge clk);
    ps_sel = 2'd3; dt_val = 12'd100;
    count_gap(1'b1, gap, ov, wr);
    check("R8 old window", gap + 1, 6);
    @(negedge clk);
    pwm_raw = 1'b0;
    count_gap(1'b0, gap, ov, wr);
    check("R8 new window", gap, 799);

    // R3: disable then re-enable
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R3 disabled", int'(out_even | out_odd), 0);
    pwm_raw = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 stays low", int'(out_even | out_odd), 0);
    ps_sel = 2'd0; dt_val = 12'd3;
    en = 1'b1;
    count_gap(1'b1, gap, ov, wr);
    check("R3 re-enable gap", gap, 3);

    // R1: reset mid-window
    @(negedge clk);
    pwm_raw = 1'b0; dt_val = 12'd50;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", int'(out_even | out_odd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 fresh window", int'(out_even | out_odd), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule